// File: doc/BRIEF.md
# PHY Register Access Port

This block sits between a host bus and the 16-bit configuration register file of a transceiver PHY. The host drives one 32-bit control word that carries the operation type, an 8-bit register address and 16 bits of write data. On accepting that word the block raises a request toward the PHY register file. It holds the request, with address, direction and write data steady, until the PHY acknowledges.

A busy bit in the readback view of the same word shows that an access is under way. Software polls that bit and, once it clears, takes any returned read value from the upper half of the word. If the PHY never acknowledges, a cycle counter gives up on the access after a set number of cycles. A sticky timeout flag then records the failure, so a stuck PHY cannot hang the host.

Top module: `phyAccessPort`

## Requirements
- R1: After a synchronous active-high reset the readback word is all zeros, busy (bit 7) is 0, the timeout flag is 0 and the PHY request is low.
- R2: A host write while idle starts an access. From the next cycle busy reads 1 and phyReq is 1. phyAddr equals word bits [15:8] and phyWdata equals word bits [31:16]. phyWe equals word bit 0, where 1 means write and 0 means read.
- R3: The readback word is laid out as {data[31:16], addr[15:8], busy[7], six zero bits [6:1], op[0]}. The address and op fields hold the values of the accepted command.
- R4: The request and its address, direction and write data stay constant while busy. Busy and phyReq drop on the cycle after phyAck is sampled high.
- R5: When a read completes, bits [31:16] hold the phyRdata value sampled with the acknowledge. When a write completes, bits [31:16] keep the write data.
- R6: A host write while busy is 1 is ignored. The outstanding access, the PHY outputs and the readback fields do not change.
- R7: phyAck while no access is outstanding has no effect on the readback word or on busy.
- R8: If no acknowledge arrives within TIMEOUT_CYCLES cycles of busy being set, the access is abandoned. Busy and phyReq drop after exactly TIMEOUT_CYCLES busy cycles, and timeoutFlag goes to 1. An acknowledge sampled in that last cycle completes the access normally instead.
- R9: timeoutFlag is sticky. Later accesses and stray acknowledges leave it at 1, and only reset clears it.
- R10: Reset during an outstanding access clears busy, drops the request and zeros the readback word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host write strobe for the control word |
| hostWrData | input | 32 | Control word written by the host |
| hostRdData | output | 32 | Control word readback with busy and returned data |
| timeoutFlag | output | 1 | Sticky flag for an abandoned access |
| phyReq | output | 1 | Access request to the PHY register file |
| phyWe | output | 1 | Request direction, 1 for write |
| phyAddr | output | 8 | PHY register address |
| phyWdata | output | 16 | PHY write data |
| phyAck | input | 1 | PHY access completion |
| phyRdata | input | 16 | PHY read data, valid with phyAck |

## Verification
The hardest cases to reach from the ports are the boundary of the timeout window. An acknowledge in the very last allowed cycle must finish normally, while one cycle less patience must abandon the access. The bench uses a small TIMEOUT_CYCLES and counts busy cycles exactly, with the acknowledge held back. It checks that busy is still high one cycle before the limit and low with the flag set at the limit. A separate run places the acknowledge in the final cycle and checks that no timeout is raised. A late acknowledge after an abandoned access is also driven, to confirm that the flag stays set and the readback word is not disturbed.

// File: rtl/phyAccessPkg.sv
package phyAccessPkg;
  typedef struct packed {
    logic load;   // accept new command word
    logic done;   // acknowledge sampled for outstanding access
  } ctlStrobes_t;
endpackage

// File: rtl/phyAccessCtl.sv
module phyAccessCtl
  import phyAccessPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostWrEn,
  input  logic        phyAck,
  output logic        busy,
  output logic        timeoutFlag,
  output ctlStrobes_t strb
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    strb.load = hostWrEn & ~busy;
    strb.done = busy & phyAck;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      waitCnt     <= '0;
      timeoutFlag <= 1'b0;
    end else if (strb.load) begin
      busy    <= 1'b1;
      waitCnt <= '0;
    end else if (busy) begin
      if (phyAck) begin
        busy <= 1'b0;
      end else if (waitCnt == CNT_LAST) begin
        busy        <= 1'b0;
        timeoutFlag <= 1'b1;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  // R2: an accepted command raises busy next cycle
  p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && !busy) |=> busy);

  // R4: acknowledge ends the access
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && phyAck) |=> !busy);

  // R9: timeout flag never drops without reset
  p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    timeoutFlag |=> timeoutFlag);

  // R8: flag rises only when an access is abandoned
  p_tmo_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(timeoutFlag) |-> ($past(busy) && !$past(phyAck) && !busy));
endmodule

// File: rtl/phyAccessDp.sv
module phyAccessDp
  import phyAccessPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strb,
  input  logic [31:0]       hostWrData,
  input  logic [DATA_W-1:0] phyRdata,
  output logic              opWrite,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ
);
  localparam int ADDR_LSB = 8;
  localparam int DATA_LSB = 16;

  always_ff @(posedge clk) begin
    if (rst) begin
      opWrite <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
    end else if (strb.load) begin
      opWrite <= hostWrData[0];
      addrQ   <= hostWrData[ADDR_LSB +: ADDR_W];
      dataQ   <= hostWrData[DATA_LSB +: DATA_W];
    end else if (strb.done && !opWrite) begin
      dataQ <= phyRdata;
    end
  end

  // R5: completed read returns the PHY data
  p_rd_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.done && !opWrite) |=> (dataQ == $past(phyRdata)));

  // R5: completed write keeps its data
  p_wr_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.done && opWrite) |=> $stable(dataQ));
endmodule

// File: rtl/phyAccessPort.sv
module phyAccessPort
  import phyAccessPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostWrEn,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        timeoutFlag,
  output logic        phyReq,
  output logic        phyWe,
  output logic [7:0]  phyAddr,
  output logic [15:0] phyWdata,
  input  logic        phyAck,
  input  logic [15:0] phyRdata
);
  ctlStrobes_t strb;
  logic        busyFlag;
  logic        opWrite;
  logic [7:0]  addrQ;
  logic [15:0] dataQ;

  phyAccessCtl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctl (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .phyAck(phyAck),
    .busy(busyFlag), .timeoutFlag(timeoutFlag), .strb(strb)
  );

  phyAccessDp #(.ADDR_W(8), .DATA_W(16)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .hostWrData(hostWrData),
    .phyRdata(phyRdata), .opWrite(opWrite), .addrQ(addrQ), .dataQ(dataQ)
  );

  assign phyReq     = busyFlag;
  assign phyWe      = opWrite;
  assign phyAddr    = addrQ;
  assign phyWdata   = dataQ;
  assign hostRdData = {dataQ, addrQ, busyFlag, 6'b0, opWrite};

  // R6: host writes during an access leave the request untouched
  p_ignore_busy_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && busyFlag) |=> ($stable(phyAddr) && $stable(phyWe)
                                && $stable(phyWdata)));

  // R4: request fields hold while waiting
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (phyReq && !phyAck) |=> (!phyReq || ($stable(phyAddr) && $stable(phyWe))));

  // R7: stray acknowledge while idle changes nothing
  p_idle_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (!phyReq && !hostWrEn) |=> ($stable(hostRdData)));
endmodule

// File: tb/phyAccessPort_bench.sv
module phyAccessPort_bench;
  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        hostWrEn;
  logic [31:0] hostWrData;
  logic [31:0] hostRdData;
  logic        timeoutFlag;
  logic        phyReq;
  logic        phyWe;
  logic [7:0]  phyAddr;
  logic [15:0] phyWdata;
  logic        phyAck;
  logic [15:0] phyRdata;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  phyAccessPort #(.TIMEOUT_CYCLES(TMO)) u_phyAccessPort (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .timeoutFlag(timeoutFlag), .phyReq(phyReq),
    .phyWe(phyWe), .phyAddr(phyAddr), .phyWdata(phyWdata),
    .phyAck(phyAck), .phyRdata(phyRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; tick(2); rst = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] w);
    hostWrEn = 1'b1; hostWrData = w;
    tick(1);
    hostWrEn = 1'b0;
  endtask

  task automatic phyRespond(input logic [15:0] d);
    phyAck = 1'b1; phyRdata = d;
    tick(1);
    phyAck = 1'b0; phyRdata = 16'h0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 word", hostRdData, 32'h0);
    check("R1 tmo", {31'b0, timeoutFlag}, 32'h0);
    check("R1 req", {31'b0, phyReq}, 32'h0);
  endtask

  task automatic testWrite();
    hostWrite(32'hBEEF_2A01);
    check("R2 req", {31'b0, phyReq}, 32'h1);
    check("R2 we", {31'b0, phyWe}, 32'h1);
    check("R2 addr", {24'b0, phyAddr}, 32'h2A);
    check("R2 wdata", {16'b0, phyWdata}, 32'hBEEF);
    check("R3 word busy", hostRdData, 32'hBEEF_2A81);
    tick(3);
    check("R4 hold", {15'b0, phyWe, phyAddr, 8'b0}, {15'b0, 1'b1, 8'h2A, 8'b0});
    phyRespond(16'h1234);
    check("R4 busy clear", {31'b0, phyReq}, 32'h0);
    check("R5 write keeps data", hostRdData, 32'hBEEF_2A01);
  endtask

  task automatic testRead();
    hostWrite(32'hFFFF_3CFE); // bit0=0 read; bits 7:1 ignored
    check("R2 read we", {31'b0, phyWe}, 32'h0);
    check("R3 read word", hostRdData, 32'hFFFF_3C80);
    phyRespond(16'hA5C3);
    check("R5 read data", hostRdData, 32'hA5C3_3C00);
  endtask

  task automatic testBusyIgnore();
    hostWrite(32'h1111_4400);
    hostWrite(32'h2222_5501);
    check("R6 addr", {24'b0, phyAddr}, 32'h44);
    check("R6 word", hostRdData, 32'h1111_4480);
    phyRespond(16'h0F0F);
    check("R6 result", hostRdData, 32'h0F0F_4400);
  endtask

  task automatic testIdleAck();
    phyRespond(16'h7777);
    check("R7 idle ack", hostRdData, 32'h0F0F_4400);
    check("R7 req", {31'b0, phyReq}, 32'h0);
  endtask

  task automatic testLastCycleAck();
    hostWrite(32'h0000_1000);
    tick(TMO - 1);
    check("R8 busy before limit", {31'b0, phyReq}, 32'h1);
    phyRespond(16'h5A5A);
    check("R8 last-cycle ack", {31'b0, timeoutFlag}, 32'h0);
    check("R8 last-cycle data", hostRdData, 32'h5A5A_1000);
  endtask

  task automatic testTimeout();
    hostWrite(32'h0000_2000);
    tick(TMO - 1);
    check("R8 still busy", {30'b0, phyReq, timeoutFlag}, 32'h2);
    tick(1);
    check("R8 abandoned", {30'b0, phyReq, timeoutFlag}, 32'h1);
    phyRespond(16'h9999);
    check("R9 late ack", hostRdData, 32'h0000_2000);
    hostWrite(32'h0001_3001);
    phyRespond(16'h0);
    check("R9 sticky", {31'b0, timeoutFlag}, 32'h1);
    doReset();
    check("R9 reset clears", {31'b0, timeoutFlag}, 32'h0);
  endtask

  task automatic testResetMid();
    hostWrite(32'hCAFE_7701);
    check("R10 pre", {31'b0, phyReq}, 32'h1);
    doReset();
    check("R10 req", {31'b0, phyReq}, 32'h0);
    check("R10 word", hostRdData, 32'h0);
  endtask

  initial begin
    rst = 1'b1; hostWrEn = 1'b0; hostWrData = '0; phyAck = 1'b0; phyRdata = '0;
    tick(1);
    testReset();
    testWrite();
    testRead();
    testBusyIgnore();
    testIdleAck();
    testLastCycleAck();
    testTimeout();
    testResetMid();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule